// File: doc/BRIEF.md
# System Port Group with Single-Bit Set/Reset

This block is a byte-wide group of system I/O ports that sits on a simple address/strobe bus. Four locations are decoded from a two-bit address. The first is a read-only constant. The second is a read-only status byte whose bit 0 follows an external status pin. The third is a full read/write byte register, called port C here. The fourth takes control words that set or clear one bit of port C without a read-modify-write sequence. Control words with the top bit set would select an operating mode, but operating modes are not part of this block, so those words are discarded.

Port C also carries a start-up quirk. A down-counter is loaded at reset and steps down once on every port C read until it reaches zero. On the reads that bring it to 4 and to 0, bit 5 of port C is forced high before the byte is returned. Software that polls port C early after reset therefore sees that bit come back on even after clearing it.

Reads are registered. A read state machine has two states. RS_IDLE means no data is presented. RS_DATA means `rd_data` holds the result of the read strobe from the previous cycle. There are two transitions. T_ACCEPT goes from either state to RS_DATA on any read strobe. T_RELEASE goes from either state to RS_IDLE when there is no read strobe.

Top module: `sysp_top`

## Requirements
- R1: A read at address 0 returns 0x73.
- R2: A read at address 1 returns 0xF8 with bit 0 replaced by `ext_status` as sampled in the strobe cycle.
- R3: A write at address 2 stores the whole byte in port C. A read at address 2 returns the stored byte.
- R4: A write at address 3 with bit 7 = 0 acts on the single port C bit indexed by write-data bits [3:1]. It sets that bit when bit 0 is 1 and clears it when bit 0 is 0. All other port C bits are kept.
- R5: A write at address 3 with bit 7 = 1 leaves port C unchanged. Writes at addresses 0 and 1 also leave port C unchanged.
- R6: After reset, port C reads 0xFF, the read counter holds 8 and `rd_valid` is 0.
- R7: Each port C read made while the counter is nonzero decrements the counter. When the new value is 4 or 0, port C bit 5 is set, and the returned byte already includes it. Once the counter is 0, reads leave it and port C unchanged. Reads of other addresses never touch the counter.
- R8: `rd_data` and `rd_valid` (high for exactly one cycle per strobe) are valid in the cycle after a read strobe. A cycle with both `bus_wr` and `bus_rd` high is treated as a write only and produces no read.
- R9: A read at address 3 returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Location select: 0 constant, 1 status, 2 port C, 3 control |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| ext_status | input | 1 | External status bit merged into the status read |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | High in the cycle `rd_data` holds a read result |

## Verification
The bench builds the block with its default parameters: a counter preload of 8, trigger values 4 and 0, and forced bit 5. With these values both forcing events fall on the fourth and eighth port C reads after reset, so a short vector walk passes through the first trigger, the second trigger and the settled counter. Clearing bit 5 through control words just before those reads makes the forced bit visible on the bus.

// File: rtl/sysp_pkg.sv
`timescale 1ns/1ps
package sysp_pkg;

    // Location codes carried on bus_addr
    typedef enum logic [1:0] {
        SEL_CONST  = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_PORTC  = 2'd2,
        SEL_CTRL   = 2'd3
    } sel_e;

    // Read response states
    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_DATA = 1'b1
    } rstate_e;

    // Decoded one-hot access strobes
    typedef struct packed {
        logic rd_const;
        logic rd_status;
        logic rd_portc;
        logic rd_ctrl;
        logic wr_portc;
        logic wr_ctrl;
    } strobe_t;

endpackage

// File: rtl/sysp_decode.sv
`timescale 1ns/1ps
module sysp_decode
    import sysp_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output strobe_t           stb
);
    sel_e sel;
    logic rd_ok;

    assign sel   = sel_e'(bus_addr[1:0]);
    // a write takes the cycle; a simultaneous read is dropped
    assign rd_ok = bus_rd && !bus_wr;

    always_comb begin
        stb = '0;
        unique case (sel)
            SEL_CONST:  stb.rd_const  = rd_ok;
            SEL_STATUS: stb.rd_status = rd_ok;
            SEL_PORTC: begin
                stb.rd_portc = rd_ok;
                stb.wr_portc = bus_wr;
            end
            SEL_CTRL: begin
                stb.rd_ctrl = rd_ok;
                stb.wr_ctrl = bus_wr;
            end
        endcase
    end
endmodule

// File: rtl/sysp_rdcount.sv
`timescale 1ns/1ps
module sysp_rdcount #(
    parameter int PRELOAD = 8,
    parameter int TRIG_A  = 4,
    parameter int TRIG_B  = 0,
    parameter int CNT_W   = $clog2(PRELOAD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_portc,
    output logic [CNT_W-1:0] cnt_q,
    output logic             force_bit
);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(PRELOAD);
    localparam logic [CNT_W-1:0] TA_V   = CNT_W'(TRIG_A);
    localparam logic [CNT_W-1:0] TB_V   = CNT_W'(TRIG_B);

    logic             live;
    logic [CNT_W-1:0] cnt_dec;

    assign live      = rd_portc && (cnt_q != '0);
    assign cnt_dec   = cnt_q - 1'b1;
    assign force_bit = live && ((cnt_dec == TA_V) || (cnt_dec == TB_V));

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= LOAD_V;
        else if (live) cnt_q <= cnt_dec;
    end
endmodule

// File: rtl/sysp_portc.sv
`timescale 1ns/1ps
module sysp_portc #(
    parameter int            W         = 8,
    parameter logic [W-1:0]  RST_VAL   = 8'hFF,
    parameter int            FORCE_POS = 5,
    parameter int            IDX_W     = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_portc,
    input  logic         wr_ctrl,
    input  logic [W-1:0] wdata,
    input  logic         force_bit,
    output logic [W-1:0] q,
    output logic [W-1:0] q_next
);
    logic [IDX_W-1:0] idx;
    logic             mode_word;
    logic [W-1:0]     onehot;

    assign idx       = wdata[IDX_W:1];
    assign mode_word = wdata[W-1];

    generate
        for (genvar b = 0; b < W; b++) begin : g_sel
            assign onehot[b] = (idx == IDX_W'(b));
        end
    endgenerate

    always_comb begin
        q_next = q;
        if (wr_portc) begin
            q_next = wdata;
        end else if (wr_ctrl && !mode_word) begin
            if (wdata[0]) q_next = q | onehot;
            else          q_next = q & ~onehot;
        end else if (force_bit) begin
            q_next[FORCE_POS] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= q_next;
    end
endmodule

// File: rtl/sysp_rdpath.sv
`timescale 1ns/1ps
module sysp_rdpath
    import sysp_pkg::*;
#(
    parameter int           W        = 8,
    parameter logic [W-1:0] CONST_V  = 8'h73,
    parameter logic [W-1:0] STAT_V   = 8'hF8,
    parameter logic [W-1:0] CTRL_RDV = 8'hFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  strobe_t      stb,
    input  logic         ext_status,
    input  logic [W-1:0] portc_next,
    output logic [W-1:0] rd_data,
    output logic         rd_valid
);
    rstate_e      state_q, state_d;
    logic         any_rd;
    logic [W-1:0] sel_data;

    assign any_rd = stb.rd_const | stb.rd_status | stb.rd_portc | stb.rd_ctrl;

    // next state: T_ACCEPT / T_RELEASE
    always_comb begin
        unique case (state_q)
            RS_IDLE: state_d = any_rd ? RS_DATA : RS_IDLE;
            RS_DATA: state_d = any_rd ? RS_DATA : RS_IDLE;
        endcase
    end

    always_comb begin
        sel_data = CTRL_RDV;
        unique case (1'b1)
            stb.rd_const:  sel_data = CONST_V;
            stb.rd_status: sel_data = {STAT_V[W-1:1], ext_status};
            stb.rd_portc:  sel_data = portc_next;
            default:       sel_data = CTRL_RDV;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (any_rd) rd_data <= sel_data;
    end

    assign rd_valid = (state_q == RS_DATA);
endmodule

// File: rtl/sysp_top.sv
`timescale 1ns/1ps
module sysp_top
    import sysp_pkg::*;
#(
    parameter int          ADDR_W    = 2,
    parameter int          W         = 8,
    parameter logic [7:0]  CONST_V   = 8'h73,
    parameter logic [7:0]  STAT_V    = 8'hF8,
    parameter logic [7:0]  CTRL_RDV  = 8'hFF,
    parameter logic [7:0]  PC_RST    = 8'hFF,
    parameter int          PRELOAD   = 8,
    parameter int          TRIG_A    = 4,
    parameter int          TRIG_B    = 0,
    parameter int          FORCE_POS = 5,
    parameter int          CNT_W     = $clog2(PRELOAD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [W-1:0]      bus_wdata,
    input  logic              ext_status,
    output logic [W-1:0]      rd_data,
    output logic              rd_valid
);
    strobe_t          stb;
    logic [CNT_W-1:0] cnt_q;
    logic             force_bit;
    logic [W-1:0]     portc_q;
    logic [W-1:0]     portc_next;

    sysp_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .stb      (stb)
    );

    sysp_rdcount #(
        .PRELOAD (PRELOAD),
        .TRIG_A  (TRIG_A),
        .TRIG_B  (TRIG_B),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_portc  (stb.rd_portc),
        .cnt_q     (cnt_q),
        .force_bit (force_bit)
    );

    sysp_portc #(
        .W         (W),
        .RST_VAL   (PC_RST[W-1:0]),
        .FORCE_POS (FORCE_POS)
    ) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_portc  (stb.wr_portc),
        .wr_ctrl   (stb.wr_ctrl),
        .wdata     (bus_wdata),
        .force_bit (force_bit),
        .q         (portc_q),
        .q_next    (portc_next)
    );

    sysp_rdpath #(
        .W        (W),
        .CONST_V  (CONST_V[W-1:0]),
        .STAT_V   (STAT_V[W-1:0]),
        .CTRL_RDV (CTRL_RDV[W-1:0])
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb        (stb),
        .ext_status (ext_status),
        .portc_next (portc_next),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );
endmodule

// File: rtl/sysp_checks.sv
`timescale 1ns/1ps
module sysp_checks #(
    parameter int ADDR_W = 2,
    parameter int W      = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [W-1:0]      bus_wdata,
    input logic              ext_status,
    input logic [W-1:0]      rd_data,
    input logic              rd_valid,
    input logic [W-1:0]      portc_q,
    input logic [CNT_W-1:0]  cnt_q
);
    logic rd_ok;
    assign rd_ok = bus_rd && !bus_wr;

    p_const_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && bus_addr == 2'd0) |=> (rd_data == 8'h73));

    p_status_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && bus_addr == 2'd1) |=> (rd_data == {7'h7C, $past(ext_status)}));

    p_portc_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2) |=> (portc_q == $past(bus_wdata)));

    p_bit_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3 && !bus_wdata[7] && bus_wdata[0])
        |=> portc_q[$past(bus_wdata[3:1])]);

    p_mode_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3 && bus_wdata[7]) |=> $stable(portc_q));

    p_cnt_monotonic_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q <= $past(cnt_q)));

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |=> rd_valid);

    p_valid_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |=> !rd_valid);
endmodule

bind sysp_top sysp_checks #(.ADDR_W(ADDR_W), .W(W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .ext_status (ext_status),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .portc_q    (portc_q),
    .cnt_q      (cnt_q)
);

// File: tb/tb_sysp_top.sv
`timescale 1ns/1ps
module tb_sysp_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       ext_status = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    sysp_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .ext_status (ext_status),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [1:0] addr;
        logic [7:0] data;
        logic       ext;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    // Port C reads before the walk: 1 (counter 8 -> 7)
    localparam vec_t VECS [22] = '{
        '{1'b0, 1'b1, 2'd0, 8'h00, 1'b0, 8'h73, 4'd1}, // R1 constant
        '{1'b0, 1'b1, 2'd1, 8'h00, 1'b0, 8'hF8, 4'd2}, // R2 status low
        '{1'b0, 1'b1, 2'd1, 8'h00, 1'b1, 8'hF9, 4'd2}, // R2 status high
        '{1'b1, 1'b0, 2'd2, 8'h00, 1'b0, 8'h00, 4'd3}, // write port C
        '{1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 8'h00, 4'd3}, // R3 read, cnt 6
        '{1'b1, 1'b0, 2'd3, 8'h0B, 1'b0, 8'h00, 4'd4}, // set bit 5
        '{1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 8'h20, 4'd4}, // R4 read, cnt 5
        '{1'b1, 1'b0, 2'd3, 8'h0A, 1'b0, 8'h00, 4'd4}, // clear bit 5
        '{1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 8'h20, 4'd7}, // R7 cnt 4 forces
        '{1'b1, 1'b0, 2'd3, 8'h8F, 1'b0, 8'h00, 4'd5}, // mode word
        '{1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 8'h20, 4'd5}, // R5 unchanged, cnt 3
        '{1'b1, 1'b0, 2'd3, 8'h0F, 1'b0, 8'h00, 4'd4}, // set bit 7
        '{1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 8'hA0, 4'd4}, // R4 read, cnt 2
        '{1'b1, 1'b0, 2'd3, 8'h01, 1'b0, 8'h00, 4'd4}, // set bit 0
        '{1'b1, 1'b0, 2'd0, 8'h55, 1'b0, 8'h00, 4'd5}, // write to constant
        '{1'b1, 1'b0, 2'd3, 8'h0A, 1'b0, 8'h00, 4'd4}, // clear bit 5
        '{1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 8'h81, 4'd5}, // R5 read, cnt 1
        '{1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 8'hA1, 4'd7}, // R7 cnt 0 forces
        '{1'b1, 1'b0, 2'd3, 8'h0A, 1'b0, 8'h00, 4'd4}, // clear bit 5
        '{1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 8'h81, 4'd7}, // R7 counter settled
        '{1'b0, 1'b1, 2'd3, 8'h00, 1'b0, 8'hFF, 4'd9}, // R9 control read
        '{1'b1, 1'b0, 2'd2, 8'h3C, 1'b0, 8'h00, 4'd3}  // write port C
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic w, input logic r, input logic [1:0] a,
                         input logic [7:0] d, input logic e);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; ext_status = e;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: no read pending after reset
        check(6, {7'd0, rd_valid}, 8'h00);
        // R6: port C resets to all ones (counter 8 -> 7, no force)
        do_op(1'b0, 1'b1, 2'd2, 8'h00, 1'b0);
        check(6, rd_data, 8'hFF);
        check(8, {7'd0, rd_valid}, 8'h01);

        for (int i = 0; i < 22; i++) begin
            do_op(VECS[i].wr, VECS[i].rd, VECS[i].addr, VECS[i].data, VECS[i].ext);
            if (VECS[i].rd) begin
                check(int'(VECS[i].req), rd_data, VECS[i].exp);
                check(8, {7'd0, rd_valid}, 8'h01);
            end
        end
        do_op(1'b0, 1'b1, 2'd2, 8'h00, 1'b0);
        check(3, rd_data, 8'h3C);

        // R8: write and read together -> write only
        do_op(1'b1, 1'b1, 2'd2, 8'h5A, 1'b0);
        check(8, {7'd0, rd_valid}, 8'h00);
        do_op(1'b0, 1'b1, 2'd2, 8'h00, 1'b0);
        check(8, rd_data, 8'h5A);

        // R2: status bit captured in the strobe cycle
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 2'd1; ext_status = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; ext_status = 1'b0;
        check(2, rd_data, 8'hF9);

        // R8: back-to-back reads, one valid cycle each, then quiet
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 2'd0;
        @(negedge clk);
        check(1, rd_data, 8'h73);
        check(8, {7'd0, rd_valid}, 8'h01);
        bus_addr = 2'd3;
        @(negedge clk);
        bus_rd = 1'b0;
        check(9, rd_data, 8'hFF);
        check(8, {7'd0, rd_valid}, 8'h01);
        @(negedge clk);
        check(8, {7'd0, rd_valid}, 8'h00);

        // R4: clear a single bit, others kept (0x5A clear bit 1 -> 0x58)
        do_op(1'b1, 1'b0, 2'd3, 8'h02, 1'b0);
        do_op(1'b0, 1'b1, 2'd2, 8'h00, 1'b0);
        check(4, rd_data, 8'h58);

        // R6: reset restores port C and counter (4th read forces bit 5)
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_op(1'b0, 1'b1, 2'd2, 8'h00, 1'b0);
        check(6, rd_data, 8'hFF);
        do_op(1'b1, 1'b0, 2'd2, 8'h00, 1'b0);
        do_op(1'b0, 1'b1, 2'd2, 8'h00, 1'b0);
        do_op(1'b0, 1'b1, 2'd2, 8'h00, 1'b0);
        check(7, rd_data, 8'h00);
        do_op(1'b0, 1'b1, 2'd2, 8'h00, 1'b0);
        check(7, rd_data, 8'h20);

        done = 1'b1;
        finish_run();
    end
endmodule